// File: doc/BRIEF.md
# Maskable Interrupt Recognition Controller

This block takes a level-sensitive maskable interrupt line and turns it into an interrupt vector for a simple in-order instruction sequencer. The line may change at any time relative to the clock, so it first passes through a two-flop synchronizer. The synchronized level is accepted only while the enable flag is set. Acceptance also waits for the sequencer's instruction-boundary strobe.

Once a request is accepted, the block runs two interrupt-acknowledge cycles back to back on a small request/ready bus. The data returned in the first cycle is ignored. The byte returned in the second cycle is latched as the vector, and a one-cycle valid pulse tells the sequencer to start servicing. If the request line drops before the sequence ends, the bus cycle in progress still completes. The block then goes back to idle without a vector.

Top module: `irq_ack_ctrl`

## Requirements
- R1: While rst_n is low, ack_req, ack_sel and vec_valid are 0 and vec_out is 0.
- R2: irq_in goes through two flops. A high level first sampled at rising edge k can start a sequence no earlier than edge k+2, so ack_req is first high in the cycle after edge k+2.
- R3: While int_en is 0 at the deciding edge, no sequence starts and ack_req stays 0.
- R4: A sequence starts only at a rising edge where insn_bound is 1, the synchronized request is 1, int_en is 1 and the block is idle. ack_req is 1 from the following cycle on.
- R5: A sequence is exactly two acknowledge cycles with ack_req held at 1 throughout. ack_sel is 0 in the first cycle and 1 in the second. Each cycle ends at a rising edge where ack_rdy is 1.
- R6: At the edge that ends the second cycle, vec_out takes ack_data and vec_valid is 1 for exactly the next cycle. Data returned with the first cycle never reaches vec_out. vec_out otherwise keeps its value.
- R7: If the synchronized request is 0 at any edge of a sequence, the current cycle still runs until its ack_rdy. The block then returns to idle with no vec_valid pulse, and vec_out is left unchanged.
- R8: ack_rdy has no effect while ack_req is 0. After every completed or aborted sequence, ack_req is 0 for at least one cycle before a new sequence can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 1 | Maskable interrupt request, level, asynchronous |
| int_en | input | 1 | Interrupt-enable flag from the sequencer |
| insn_bound | input | 1 | Instruction-boundary strobe |
| ack_req | output | 1 | Acknowledge bus cycle request |
| ack_sel | output | 1 | 0 = first acknowledge cycle, 1 = second |
| ack_rdy | input | 1 | Bus ready, ends the current acknowledge cycle |
| ack_data | input | VEC_W | Data returned by the system during acknowledge |
| vec_valid | output | 1 | One-cycle pulse: vector available |
| vec_out | output | VEC_W | Captured interrupt vector |

## Verification
Each result is due at a fixed number of rising edges after its stimulus. ack_req rises one cycle after the deciding edge, and that edge is at least two edges after irq_in is first sampled high. ack_sel advances at the edge that carries ack_rdy. vec_valid and vec_out change at the edge that ends the second cycle. The bench drives all inputs on falling edges and runs its own model of these rules on rising edges. It compares every output at the falling edge that follows, which is half a cycle after each result settles. Random phases are mixed with directed ones: a masked phase, a boundary-starved phase, a phase of ready pulses with no request active, and a drop in the middle of a sequence.

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_in,
  input  logic             int_en,
  input  logic             insn_bound,
  output logic             ack_req,
  output logic             ack_sel,
  input  logic             ack_rdy,
  input  logic [VEC_W-1:0] ack_data,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_out
);

  typedef enum logic [1:0] {S_IDLE, S_ACK1, S_ACK2} st_t;

  st_t  st;
  logic sync_a, sync_b;
  logic drop_q;

  wire abort = drop_q | ~sync_b;
  wire take  = (st == S_IDLE) & sync_b & int_en & insn_bound;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= irq_in;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      drop_q    <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      vec_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          drop_q <= 1'b0;
          if (take) st <= S_ACK1;
        end
        S_ACK1: begin
          drop_q <= abort;
          if (ack_rdy) st <= abort ? S_IDLE : S_ACK2;
        end
        S_ACK2: begin
          drop_q <= abort;
          if (ack_rdy) begin
            st <= S_IDLE;
            if (!abort) begin
              vec_out   <= ack_data;
              vec_valid <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ack_req = (st != S_IDLE);
  assign ack_sel = (st == S_ACK2);

  p_start_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> $past(int_en && insn_bound && sync_b));

  p_hold_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_rdy) |=> (ack_req && $stable(ack_sel)));

  p_second_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_sel && ack_rdy && !abort) |=> (ack_req && ack_sel));

  p_pulse_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  p_pulse_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack_req && ack_sel && ack_rdy));

  p_vec_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> $stable(vec_out));

  p_gap_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && ack_sel && ack_rdy) |=> !ack_req);

endmodule

// File: tb/irq_ack_ctrl_tb.sv
module irq_ack_ctrl_tb_top;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_in = 1'b0, int_en = 1'b0, insn_bound = 1'b0, ack_rdy = 1'b0;
  logic [VW-1:0] ack_data = '0;
  logic ack_req, ack_sel, vec_valid;
  logic [VW-1:0] vec_out;

  int total = 0, bad = 0;
  bit done = 0;
  string req_tag = "R4";

  always #2 clk = ~clk;

  irq_ack_ctrl #(.VEC_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_en(int_en),
    .insn_bound(insn_bound), .ack_req(ack_req), .ack_sel(ack_sel),
    .ack_rdy(ack_rdy), .ack_data(ack_data), .vec_valid(vec_valid),
    .vec_out(vec_out)
  );

  // bench model of the requirements, updated on rising edges
  logic m_s1, m_s2, m_dr, m_vv;
  logic [1:0] m_ph;
  logic [VW-1:0] m_vec;

  function automatic logic gave_up(logic dr, logic lvl);
    return dr || !lvl;
  endfunction

  function automatic logic may_start(logic ph0, logic lvl, logic en, logic bnd);
    return ph0 && lvl && en && bnd;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_dr <= 0; m_vv <= 0; m_ph <= 0; m_vec <= '0;
    end else begin
      m_s1 <= irq_in;
      m_s2 <= m_s1;
      m_vv <= 0;
      if (m_ph == 0) begin
        m_dr <= 0;
        if (may_start(1'b1, m_s2, int_en, insn_bound)) m_ph <= 1;
      end else begin
        m_dr <= gave_up(m_dr, m_s2);
        if (ack_rdy) begin
          if (m_ph == 1 && !gave_up(m_dr, m_s2)) m_ph <= 2;
          else begin
            if (m_ph == 2 && !gave_up(m_dr, m_s2)) begin
              m_vv <= 1; m_vec <= ack_data;
            end
            m_ph <= 0;
          end
        end
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(req_tag, "ack_req", ack_req, (m_ph != 0));
    chk("R5", "ack_sel", ack_sel, (m_ph == 2));
    chk("R7", "vec_valid", vec_valid, m_vv);
    chk("R6", "vec_out", vec_out, m_vec);
  endtask

  task automatic step(int p_irq, int p_bnd, int p_rdy, bit en_val);
    @(negedge clk);
    compare_all();
    if ($urandom_range(99) < p_irq) irq_in = ~irq_in;
    int_en = en_val;
    insn_bound = ($urandom_range(99) < p_bnd);
    ack_rdy = ($urandom_range(99) < p_rdy);
    ack_data = VW'($urandom);
  endtask

  initial begin
    void'($urandom(32'h1A2B3C));
    // R1: reset values
    repeat (3) @(negedge clk);
    chk("R1", "ack_req", ack_req, 0);
    chk("R1", "ack_sel", ack_sel, 0);
    chk("R1", "vec_valid", vec_valid, 0);
    chk("R1", "vec_out", vec_out, 0);
    rst_n = 1;

    // R2: two-flop delay from irq_in to the start of a sequence
    req_tag = "R2";
    @(negedge clk);
    irq_in = 1; int_en = 1; insn_bound = 1;
    @(negedge clk); chk("R2", "ack_req edge1", ack_req, 0);
    @(negedge clk); chk("R2", "ack_req edge2", ack_req, 0);
    @(negedge clk); chk("R2", "ack_req edge3", ack_req, 1);
    // finish the clean sequence, first data must be ignored (R6)
    ack_rdy = 1; ack_data = 8'h11;
    @(negedge clk); compare_all();
    ack_data = 8'hC5;
    @(negedge clk); compare_all();
    chk("R6", "vec after two cycles", vec_out, 8'hC5);
    chk("R6", "pulse", vec_valid, 1);
    ack_rdy = 0;
    // R8: at least one idle cycle after completion
    chk("R8", "gap", ack_req, 0);
    irq_in = 0;
    repeat (4) step(0, 50, 0, 1'b1);

    // R7: drop in the middle of a sequence
    irq_in = 1; insn_bound = 1; int_en = 1;
    repeat (4) begin @(negedge clk); compare_all(); end
    irq_in = 0;
    repeat (4) begin @(negedge clk); compare_all(); end
    ack_rdy = 1; ack_data = 8'h77;
    repeat (3) begin @(negedge clk); compare_all(); end
    chk("R7", "vec kept", vec_out, 8'hC5);
    ack_rdy = 0;

    // R3: masked phase
    req_tag = "R3";
    repeat (1500) step(5, 40, 50, 1'b0);
    // R4: boundary-starved then random
    req_tag = "R4";
    repeat (300) step(5, 0, 50, 1'b1);
    repeat (3000) step(3, 25, 45, ($urandom_range(9) != 0));
    // R8: ready storms with the request line low
    req_tag = "R8";
    irq_in = 0;
    repeat (4) step(0, 50, 0, 1'b1);
    repeat (500) begin
      step(0, 60, 100, 1'b1);
      chk("R8", "no vector while idle", vec_valid, 0);
    end
    req_tag = "R4";
    repeat (2000) step(8, 30, 60, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule